// File: doc/BRIEF.md
# Unrolled Successive-Cancellation Polar Decoder (16,8)

This block decodes one fixed polar code of length 16 carrying 8 message bits. The code tree is walked depth-first, as successive cancellation requires. Every node visit is laid out as its own piece of hardware, with a register bank behind it. A whole frame of 16 channel log-likelihood ratios enters in one cycle. Sixteen decided message bits leave a fixed number of cycles later, and the pipeline can take a fresh frame on every clock.

The tree is pruned before it is built:

- The first quarter of the message is all frozen, so it never gets a node. Its partial sums are known zeros and are folded into the parent's g step.
- The second quarter is a repetition code and is decided by one summing node.
- The third quarter is a single-parity-check code with one correcting node.
- The last quarter is all information. It is read straight off the signs of its parent's g outputs.

This leaves seven register stages in place of the 61 that an unpruned traversal would need.

The stream interface carries a valid qualifier only. No ready signal exists, and the block never applies back-pressure: the input is always ready, and the consumer must take every output beat when `out_valid` is high.

Top module: `polar_sc_unrolled`

## Requirements
- R1: Lane i of `in_llr` (bits [6i+5:6i], i = 0..15) holds the signed two's-complement LLR of codeword bit i. Bit i of `out_bits` is the decision on message bit u_i. The codeword is built from the message recursively: the word of a node is (left XOR right, right), with the lower index half first.
- R2: A frame sampled with `in_valid` high at a rising edge is presented with `out_valid` high just after the sixth edge that follows it. This gives seven register stages. Each frame sampled produces exactly one output beat, frames leave in arrival order, and a frame may be sampled on every edge.
- R3: A synchronous active-high `rst` drives `out_valid` and `out_bits` to zero and discards every frame still inside the pipeline.
- R4: Message positions 0 to 6 and 8 are frozen and always read 0. Positions 7 and 9 to 15 carry information.
- R5: The left-child LLR is the min-sum f: the product of the two signs times the smaller magnitude. The right-child LLR is g: b+a when the left partial-sum bit is 0, and b−a when it is 1. Both saturate to the range [−32, 31]. A hard decision maps a negative LLR to 1 and zero or positive to 0.
- R6: u7 is 1 exactly when the full-precision sum of the four LLRs reaching the repetition node is negative. A sum of zero gives 0.
- R7: For positions 8 to 11, the parity-check node takes hard decisions of its four LLRs. If their parity is odd, it flips the one with the smallest magnitude, and the lowest index wins a tie. u8 to u11 are the transform of the corrected word.
- R8: u12 to u15 are the transform of the hard decisions of the four g outputs feeding the last quarter.
- R9: Any message on the information positions, encoded and mapped to LLR +31 for a 0 bit and −32 for a 1 bit, is decoded exactly.
- R10: While `out_valid` is low, `out_bits` keeps the last decoded frame, or zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Frame present on `in_llr` this cycle |
| in_llr | input | 96 | Sixteen 6-bit signed channel LLRs, lane i at [6i+5:6i] |
| out_valid | output | 1 | Decoded frame present on `out_bits` |
| out_bits | output | 16 | Decoded message bits, bit i is u_i |

## Verification
The hardest states to reach from the ports are a repetition sum of exactly zero and a parity-check node that sees odd parity with tied smallest magnitudes. Random channel values rarely produce either after two levels of f and g arithmetic. The stimulus sets the first half of the frame to zero, which turns every f on the left side into zero and makes each root g pass the upper LLRs through unchanged. The chosen values then reach the repetition and parity nodes directly, and the tie and zero-sum patterns are built there by hand. A reset issued while frames are in flight, together with runs of all −32 and all +31 inputs, covers flushing and saturation.

// File: rtl/polar_pkg.sv
package polar_pkg;
  localparam int CW_N = 16;
  localparam int PIPE_LAT = 7;
  localparam logic [CW_N-1:0] FROZEN_MASK = 16'h017F;

  // Length-4 polar transform (self-inverse): word = (left ^ right, right)
  function automatic logic [3:0] polar_xform4(input logic [3:0] b);
    logic [3:0] t;
    t = b;
    t[0] = t[0] ^ t[1];
    t[2] = t[2] ^ t[3];
    t[0] = t[0] ^ t[2];
    t[1] = t[1] ^ t[3];
    return t;
  endfunction
endpackage

// File: rtl/polar_f_vec.sv
module polar_f_vec #(
  parameter int W = 6,
  parameter int LANES = 8
) (
  input  logic [LANES*W-1:0] a_i,
  input  logic [LANES*W-1:0] b_i,
  output logic [LANES*W-1:0] y_o
);
  localparam int EW = W + 2;
  localparam logic signed [EW-1:0] HI_E = EW'(2 ** (W - 1) - 1);
  localparam logic signed [EW-1:0] LO_E = -EW'(2 ** (W - 1));

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [EW-1:0] ea, eb, ma, mb, m, r;
    logic [W-1:0] y;
    always_comb begin
      ea = EW'($signed(a_i[k*W +: W]));
      eb = EW'($signed(b_i[k*W +: W]));
      ma = ea[EW-1] ? -ea : ea;
      mb = eb[EW-1] ? -eb : eb;
      m  = (ma < mb) ? ma : mb;
      r  = (ea[EW-1] ^ eb[EW-1]) ? -m : m;
      if (r > HI_E)      y = HI_E[W-1:0];
      else if (r < LO_E) y = LO_E[W-1:0];
      else               y = r[W-1:0];
    end
    assign y_o[k*W +: W] = y;
  end
endmodule

// File: rtl/polar_g_vec.sv
module polar_g_vec #(
  parameter int W = 6,
  parameter int LANES = 8
) (
  input  logic [LANES*W-1:0] a_i,
  input  logic [LANES*W-1:0] b_i,
  input  logic [LANES-1:0]   u_i,
  output logic [LANES*W-1:0] y_o
);
  localparam int EW = W + 2;
  localparam logic signed [EW-1:0] HI_E = EW'(2 ** (W - 1) - 1);
  localparam logic signed [EW-1:0] LO_E = -EW'(2 ** (W - 1));

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [EW-1:0] ea, eb, r;
    logic [W-1:0] y;
    always_comb begin
      ea = EW'($signed(a_i[k*W +: W]));
      eb = EW'($signed(b_i[k*W +: W]));
      r  = u_i[k] ? (eb - ea) : (eb + ea);
      if (r > HI_E)      y = HI_E[W-1:0];
      else if (r < LO_E) y = LO_E[W-1:0];
      else               y = r[W-1:0];
    end
    assign y_o[k*W +: W] = y;
  end
endmodule

// File: rtl/polar_rep.sv
module polar_rep #(
  parameter int W = 6,
  parameter int LEN = 4
) (
  input  logic [LEN*W-1:0] llr_i,
  output logic             bit_o
);
  localparam int SW = W + $clog2(LEN) + 1;
  logic signed [SW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int j = 0; j < LEN; j++) acc = acc + SW'($signed(llr_i[j*W +: W]));
    bit_o = acc[SW-1];
  end
endmodule

// File: rtl/polar_spc.sv
module polar_spc #(
  parameter int W = 6,
  parameter int LEN = 4
) (
  input  logic [LEN*W-1:0] llr_i,
  output logic [LEN-1:0]   beta_o
);
  localparam int IW = $clog2(LEN);
  logic [LEN-1:0] hard;
  logic [W:0]     mag [LEN];
  logic [W:0]     best_mag;
  logic [IW-1:0]  best;
  logic           odd;

  for (genvar k = 0; k < LEN; k++) begin : g_lane
    logic signed [W:0] e;
    assign e       = (W + 1)'($signed(llr_i[k*W +: W]));
    assign hard[k] = e[W];
    assign mag[k]  = e[W] ? -e : e;
  end

  always_comb begin
    odd      = ^hard;
    best     = '0;
    best_mag = mag[0];
    for (int j = 1; j < LEN; j++) begin
      if (mag[j] < best_mag) begin
        best_mag = mag[j];
        best     = IW'(j);
      end
    end
    beta_o = hard;
    if (odd) beta_o[best] = ~hard[best];
  end
endmodule

// File: rtl/polar_sc_unrolled.sv
module polar_sc_unrolled
  import polar_pkg::*;
#(
  parameter int LLR_W = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [CW_N*LLR_W-1:0]   in_llr,
  output logic                    out_valid,
  output logic [CW_N-1:0]         out_bits
);
  localparam int H = CW_N / 2;
  localparam int Q = CW_N / 4;

  // stage 1: root f -> left-half LLRs
  logic [H*LLR_W-1:0] s1_l8, p1_l8;
  logic [CW_N*LLR_W-1:0] p1_root, p2_root, p3_root;
  logic p1_v, p2_v, p3_v, p4_v, p5_v, p6_v;

  polar_f_vec #(.W(LLR_W), .LANES(H)) u_root_f (
    .a_i(in_llr[0 +: H*LLR_W]), .b_i(in_llr[H*LLR_W +: H*LLR_W]), .y_o(s1_l8));

  // stage 2: frozen first quarter merged, g with zero partial sums
  logic [Q*LLR_W-1:0] s2_b4, p2_b4;
  polar_g_vec #(.W(LLR_W), .LANES(Q)) u_l8_g (
    .a_i(p1_l8[0 +: Q*LLR_W]), .b_i(p1_l8[Q*LLR_W +: Q*LLR_W]),
    .u_i({Q{1'b0}}), .y_o(s2_b4));

  // stage 3: repetition node
  logic s3_rb, p3_rb, p4_rb, p5_rb, p6_rb;
  polar_rep #(.W(LLR_W), .LEN(Q)) u_rep (.llr_i(p2_b4), .bit_o(s3_rb));

  // stage 4: root g, left partial sums all equal the repetition bit
  logic [H*LLR_W-1:0] s4_r8, p4_r8, p5_r8, p6_r8;
  polar_g_vec #(.W(LLR_W), .LANES(H)) u_root_g (
    .a_i(p3_root[0 +: H*LLR_W]), .b_i(p3_root[H*LLR_W +: H*LLR_W]),
    .u_i({H{p3_rb}}), .y_o(s4_r8));

  // stage 5: right-half f
  logic [Q*LLR_W-1:0] s5_c4, p5_c4;
  polar_f_vec #(.W(LLR_W), .LANES(Q)) u_r8_f (
    .a_i(p4_r8[0 +: Q*LLR_W]), .b_i(p4_r8[Q*LLR_W +: Q*LLR_W]), .y_o(s5_c4));

  // stage 6: single-parity-check node
  logic [Q-1:0] s6_bc, p6_bc;
  polar_spc #(.W(LLR_W), .LEN(Q)) u_spc (.llr_i(p5_c4), .beta_o(s6_bc));

  // stage 7: right-half g with rate-1 quarter merged as hard decisions
  logic [Q*LLR_W-1:0] s7_d4;
  logic [Q-1:0]       s7_bd;
  logic [CW_N-1:0]    s7_u;
  polar_g_vec #(.W(LLR_W), .LANES(Q)) u_r8_g (
    .a_i(p6_r8[0 +: Q*LLR_W]), .b_i(p6_r8[Q*LLR_W +: Q*LLR_W]),
    .u_i(p6_bc), .y_o(s7_d4));

  for (genvar j = 0; j < Q; j++) begin : g_hard
    assign s7_bd[j] = $signed(s7_d4[j*LLR_W +: LLR_W]) < 0;
  end

  assign s7_u = {polar_xform4(s7_bd), polar_xform4(p6_bc), p6_rb, 7'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      {p1_v, p2_v, p3_v, p4_v, p5_v, p6_v} <= '0;
      out_valid <= 1'b0;
      out_bits  <= '0;
    end else begin
      p1_v <= in_valid;
      p2_v <= p1_v;
      p3_v <= p2_v;
      p4_v <= p3_v;
      p5_v <= p4_v;
      p6_v <= p5_v;
      out_valid <= p6_v;
      if (p6_v) out_bits <= s7_u;
    end
  end

  always_ff @(posedge clk) begin
    p1_root <= in_llr;  p1_l8 <= s1_l8;
    p2_root <= p1_root; p2_b4 <= s2_b4;
    p3_root <= p2_root; p3_rb <= s3_rb;
    p4_rb   <= p3_rb;   p4_r8 <= s4_r8;
    p5_rb   <= p4_rb;   p5_r8 <= p4_r8; p5_c4 <= s5_c4;
    p6_rb   <= p5_rb;   p6_r8 <= p5_r8; p6_bc <= s6_bc;
  end
endmodule

// File: rtl/polar_sc_chk.sv
module polar_sc_chk
  import polar_pkg::*;
#(
  parameter int LAT = PIPE_LAT
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            out_valid,
  input logic [CW_N-1:0] out_bits
);
  logic [LAT-1:0] shadow;

  always_ff @(posedge clk) begin
    if (rst) shadow <= '0;
    else     shadow <= {shadow[LAT-2:0], in_valid};
  end

  // R3
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_bits == '0));

  // R2
  latency_match_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == shadow[LAT-1]);

  // R4
  frozen_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_bits & FROZEN_MASK) == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(out_bits));
endmodule

bind polar_sc_unrolled polar_sc_chk #(.LAT(polar_pkg::PIPE_LAT)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_bits(out_bits));

// File: tb/sim_polar_sc_unrolled.sv
module sim_polar_sc_unrolled;
  localparam int W = 6;
  localparam int NB = 16;
  localparam int HI = 31;
  localparam int LO = -32;
  localparam logic [15:0] INFO = 16'hFE80;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [NB*W-1:0] in_llr = '0;
  logic out_valid;
  logic [NB-1:0] out_bits;

  polar_sc_unrolled #(.LLR_W(W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_llr(in_llr),
    .out_valid(out_valid), .out_bits(out_bits));

  always #10ns clk = ~clk;

  int pc = 0;
  always @(posedge clk) pc <= pc + 1;

  logic        hist_v [64];
  logic [15:0] hist_d [64];
  string       hist_r [64];
  logic [15:0] exp_last = '0;
  bit armed = 0;
  int n_cmp = 0;
  int n_bad = 0;

  function automatic int sat(input int x);
    return (x > HI) ? HI : ((x < LO) ? LO : x);
  endfunction

  function automatic int iabs(input int x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic int fmin(input int a, input int b);
    int m;
    m = (iabs(a) < iabs(b)) ? iabs(a) : iabs(b);
    return sat(((a < 0) != (b < 0)) ? -m : m);
  endfunction

  function automatic int gsum(input int a, input int b, input bit u);
    return sat(u ? (b - a) : (b + a));
  endfunction

  function automatic logic [15:0] xf(input logic [15:0] v, input int n);
    for (int s = 1; s < n; s = s * 2)
      for (int i = 0; i < n; i++)
        if ((i & s) == 0) v[i] = v[i] ^ v[i+s];
    return v;
  endfunction

  // bench model of the pruned decoder, built from R5..R8
  function automatic logic [15:0] ref_dec(input logic [NB*W-1:0] v);
    int l [16]; int a8 [8]; int r8 [8]; int c4 [4];
    int sum, best; bit rb, par;
    logic [15:0] hc, hd, t, u;
    for (int i = 0; i < 16; i++) l[i] = int'($signed(v[i*W +: W]));
    for (int j = 0; j < 8; j++) a8[j] = fmin(l[j], l[j+8]);
    sum = 0;
    for (int j = 0; j < 4; j++) sum += gsum(a8[j], a8[j+4], 1'b0);
    rb = (sum < 0);
    for (int j = 0; j < 8; j++) r8[j] = gsum(l[j], l[j+8], rb);
    hc = '0; par = 0;
    for (int j = 0; j < 4; j++) begin
      c4[j] = fmin(r8[j], r8[j+4]);
      hc[j] = (c4[j] < 0);
      par = par ^ hc[j];
    end
    if (par) begin
      best = 0;
      for (int j = 1; j < 4; j++) if (iabs(c4[j]) < iabs(c4[best])) best = j;
      hc[best] = ~hc[best];
    end
    hd = '0;
    for (int j = 0; j < 4; j++) hd[j] = (gsum(r8[j], r8[j+4], hc[j]) < 0);
    u = '0;
    u[7] = rb;
    t = xf(hc, 4); u[11:8] = t[3:0];
    t = xf(hd, 4); u[15:12] = t[3:0];
    return u;
  endfunction

  function automatic logic [NB*W-1:0] pk(input int l [16]);
    logic [NB*W-1:0] v;
    for (int i = 0; i < 16; i++) v[i*W +: W] = W'(sat(l[i]));
    return v;
  endfunction

  function automatic logic [NB*W-1:0] enc(input logic [15:0] u, input int noise);
    int l [16]; logic [15:0] x;
    x = xf(u, 16);
    for (int i = 0; i < 16; i++)
      l[i] = (x[i] ? LO : HI) + ((noise > 0) ? int'($urandom % (2*noise+1)) - noise : 0);
    return pk(l);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input logic [NB*W-1:0] llr, input logic [15:0] e, input string tag);
    @(posedge clk);
    #2ns;
    in_valid = v;
    in_llr = llr;
    hist_v[(pc+1) & 63] = v;
    hist_d[(pc+1) & 63] = e;
    hist_r[(pc+1) & 63] = tag;
  endtask

  task automatic frame(input logic [NB*W-1:0] llr, input string tag);
    cyc(1'b1, llr, ref_dec(llr), tag);
  endtask

  // output monitor: half a period after each edge
  always @(negedge clk) begin
    int idx;
    if (armed && !rst) begin
      idx = (pc - 6) & 63;
      chk("R2 valid timing", {15'b0, out_valid}, {15'b0, hist_v[idx]});
      if (hist_v[idx]) begin
        exp_last = hist_d[idx];
        chk(hist_r[idx], out_bits, exp_last);
      end else begin
        chk("R10 R3 idle value", out_bits, exp_last);
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int l [16];
    logic [15:0] msg;
    int kind;
    void'($urandom(32'h0C0D_E516));
    for (int i = 0; i < 64; i++) begin hist_v[i] = 1'b0; hist_d[i] = '0; hist_r[i] = "-"; end

    rst = 1'b1;
    repeat (3) cyc(1'b0, '0, '0, "-");
    rst = 1'b0;
    armed = 1;
    @(negedge clk);
    // R3: reset state
    chk("R3 reset out_valid", {15'b0, out_valid}, 16'h0);
    chk("R3 reset out_bits", out_bits, 16'h0);

    // R1: all-zero LLRs give all-zero message
    frame('0, "R1 zero frame");
    // R6: first half zero makes the repetition sum exactly zero -> u7 = 0
    for (int i = 0; i < 8; i++) l[i] = 0;
    for (int i = 8; i < 16; i++) l[i] = int'($urandom % 64) - 32;
    frame(pk(l), "R6 zero sum");
    // R6: negative repetition sum -> u7 = 1
    for (int i = 0; i < 8; i++) l[i] = -20;
    for (int i = 8; i < 16; i++) l[i] = 25;
    frame(pk(l), "R6 negative sum");
    // R7: odd parity, all magnitudes tied at 5, index 0 flips -> all zero
    for (int i = 0; i < 8; i++) l[i] = 0;
    l[8] = -5; l[9] = 5; l[10] = 5; l[11] = 5;
    for (int i = 12; i < 16; i++) l[i] = 31;
    cyc(1'b1, pk(l), 16'h0000, "R7 tie at index 0");
    // R7: odd parity, tie between indices 1 and 2, index 1 flips
    l[8] = 7; l[9] = -3; l[10] = 3; l[11] = 9;
    frame(pk(l), "R7 tie lowest index");
    // R8: strong negative last quarter with even parity word
    for (int i = 8; i < 12; i++) l[i] = 20;
    for (int i = 12; i < 16; i++) l[i] = -32;
    frame(pk(l), "R8 rate-1 quarter");
    // R5: saturation extremes
    for (int i = 0; i < 16; i++) l[i] = -32;
    frame(pk(l), "R5 all negative saturation");
    for (int i = 0; i < 16; i++) l[i] = 31;
    frame(pk(l), "R5 all positive");
    // R9: noiseless codewords back to back
    cyc(1'b1, enc(INFO, 0), INFO, "R9 noiseless all info ones");
    for (int k = 0; k < 8; k++) begin
      msg = 16'($urandom) & INFO;
      cyc(1'b1, enc(msg, 0), msg, "R9 noiseless");
    end
    cyc(1'b0, '0, '0, "-");

    // R3: reset with frames in flight, none may emerge
    for (int k = 0; k < 3; k++) begin
      msg = 16'($urandom) & INFO;
      cyc(1'b1, enc(msg, 0), msg, "R3 flushed frame");
    end
    @(posedge clk);
    #2ns;
    rst = 1'b1;
    in_valid = 1'b0;
    for (int i = 0; i < 64; i++) hist_v[i] = 1'b0;
    exp_last = '0;
    repeat (2) cyc(1'b0, '0, '0, "-");
    rst = 1'b0;
    repeat (8) cyc(1'b0, '0, '0, "-");

    // random traffic with gaps and back-to-back runs
    for (int n = 0; n < 1500; n++) begin
      if (($urandom % 4) == 0) begin
        cyc(1'b0, $urandom, '0, "-");
      end else begin
        kind = int'($urandom % 3);
        if (kind == 0) begin
          for (int i = 0; i < 16; i++) l[i] = int'($urandom % 64) - 32;
          frame(pk(l), "R5 random LLRs");
        end else if (kind == 1) begin
          msg = 16'($urandom) & INFO;
          frame(enc(msg, 40), "R7 R8 noisy codeword");
        end else begin
          msg = 16'($urandom) & INFO;
          cyc(1'b1, enc(msg, 0), msg, "R9 random noiseless");
        end
      end
    end
    repeat (12) cyc(1'b0, '0, '0, "-");
    @(negedge clk);
    finish_run();
  end
endmodule